// File: doc/BRIEF.md
# Multi-Cycle Instruction Bus Sequencer

This block is the control unit of a tiny 8-bit processor. It breaks every instruction into typed bus machine cycles (opcode fetch, memory read, memory write, I/O read, I/O write) and steps each one through numbered T-states, one T-state per clock. It drives a bus whose low address byte shares its pins with the data byte. The bus has an address-latch strobe, active-low read and write strobes and a select line that marks I/O cycles.

Four opcodes are executed:

| Opcode | Function |
|--------|----------|
| 34H | Increment the memory byte addressed by the H:L pair |
| 06H | Load an immediate byte into B |
| 32H | Store the accumulator at a direct 16-bit address |
| DBH | Read an I/O port into the accumulator |

Every other opcode is treated as a no-operation. A status pair (cycle type and T-state number) lets a system or a bench follow the exact cycle sequence. The accumulator and B are also brought out for observation.

H:L and the accumulator start from parameter values at reset, and the program counter starts at a parameter address.

Top module: `bus_sequencer`

## Requirements
- R1: While reset is low, the block shows an opcode fetch in T-state 1 with both strobes high, the I/O select low and the reset program address on the address bus. The first fetch after reset reads from that address.
- R2: An opcode fetch lasts exactly 4 T-states. It reads the opcode from the program counter address during T1 to T3. T4 is internal, with both strobes high and the data pins at 00H.
- R3: Memory read, memory write and I/O read cycles each last exactly 3 T-states, and the next cycle starts in T1 right after.
- R4: In every cycle, the address-latch strobe is high in T1 only, with the full 16-bit address driven (high byte on its own pins, low byte on the shared pins). The read strobe (reads) or the write strobe (writes) is low in T2 and T3. During a write the data is on the shared pins in T2 and T3. During a read those pins show 00H.
- R5: Opcode 34H runs a fetch, then a memory read at H:L, then a memory write at H:L of the read byte plus one.
- R6: Opcode 06H runs a fetch, then a memory read of the next program byte. That byte is loaded into B (visible on `b_out`).
- R7: Opcode 32H runs a fetch, then two memory reads of the next program bytes (low, then high address byte), then a memory write of the accumulator to the address high:low.
- R8: Opcode DBH runs a fetch, then a memory read of the port number, then an I/O read with the port number on both address bytes and the I/O select high. The byte read is loaded into the accumulator (visible on `acc_out`).
- R9: The program counter advances by one after each byte read from program memory (opcodes and operands). It does not advance after data-memory or I/O cycles.
- R10: Any opcode other than 34H, 06H, 32H and DBH costs a single 4 T-state fetch, followed at once by the fetch of the next byte.
- R11: The status output `mc_type` encodes the cycle as 0 fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. `tstate` counts 1 upward within each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_data | input | 8 | Data returned by memory or I/O, sampled at the end of T3 |
| addr_hi | output | 8 | High address byte (port number during I/O cycles) |
| ad_out | output | 8 | Shared pins: low address byte in T1, write data in T2 and T3 |
| ale | output | 1 | Address-latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | High during I/O cycles, low for memory |
| mc_type | output | 3 | Current machine-cycle type |
| tstate | output | 3 | Current T-state number |
| acc_out | output | 8 | Accumulator contents |
| b_out | output | 8 | Register B contents |

## Verification
All bus outputs are decoded from the current T-state. Each T-state is therefore visible in the same clock period it names, and the bench samples every one of them on the falling edge. Bytes read are captured on the rising edge that ends T3, so a loaded register or an advanced program counter is first checked at the T1 of the following cycle. Reset release passes through a two-stage synchronizer. The bench therefore lets two rising edges pass after raising `rst_n` before it treats the next falling edge as T1 of the first fetch, and it then walks each instruction cycle by cycle with the exact T-state count.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;
  typedef enum logic [2:0] {
    MC_OF  = 3'd0,
    MC_MR  = 3'd1,
    MC_MW  = 3'd2,
    MC_IOR = 3'd3,
    MC_IOW = 3'd4
  } mc_e;

  typedef enum logic [1:0] {
    AS_PC   = 2'd0,
    AS_HL   = 2'd1,
    AS_WZ   = 2'd2,
    AS_PORT = 2'd3
  } asel_e;

  localparam logic [7:0] OP_INC_IND = 8'h34;
  localparam logic [7:0] OP_LD_B    = 8'h06;
  localparam logic [7:0] OP_ST_DIR  = 8'h32;
  localparam logic [7:0] OP_PORT_IN = 8'hDB;
endpackage

// File: rtl/bseq_rst_sync.sv
`timescale 1ns/1ps
module bseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      rst_q  <= stage1;
    end
  end
endmodule

// File: rtl/bseq_tstate.sv
`timescale 1ns/1ps
module bseq_tstate #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          four,
  output logic [TW-1:0] t_q,
  output logic          last
);
  logic [TW-1:0] t_d;

  assign last = four ? (t_q == TW'(4)) : (t_q == TW'(3));

  always_comb begin
    t_d = last ? TW'(1) : t_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= TW'(1);
    else        t_q <= t_d;
  end
endmodule

// File: rtl/bseq_decode.sv
`timescale 1ns/1ps
module bseq_decode
  import bseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 2
) (
  input  logic [DW-1:0] opc,
  input  logic [SW-1:0] step,
  output logic          valid,
  output mc_e           mc,
  output asel_e         asel
);
  always_comb begin
    valid = 1'b0;
    mc    = MC_OF;
    asel  = AS_PC;
    case (opc)
      OP_INC_IND: begin
        if (step == SW'(1)) begin valid = 1'b1; mc = MC_MR; asel = AS_HL; end
        if (step == SW'(2)) begin valid = 1'b1; mc = MC_MW; asel = AS_HL; end
      end
      OP_LD_B: begin
        if (step == SW'(1)) begin valid = 1'b1; mc = MC_MR; asel = AS_PC; end
      end
      OP_ST_DIR: begin
        if (step == SW'(1)) begin valid = 1'b1; mc = MC_MR; asel = AS_PC; end
        if (step == SW'(2)) begin valid = 1'b1; mc = MC_MR; asel = AS_PC; end
        if (step == SW'(3)) begin valid = 1'b1; mc = MC_MW; asel = AS_WZ; end
      end
      OP_PORT_IN: begin
        if (step == SW'(1)) begin valid = 1'b1; mc = MC_MR; asel = AS_PC;   end
        if (step == SW'(2)) begin valid = 1'b1; mc = MC_IOR; asel = AS_PORT; end
      end
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/bus_sequencer.sv
`timescale 1ns/1ps
module bus_sequencer
  import bseq_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            AW      = 16,
  parameter logic [AW-1:0] PC_INIT = 16'h2000,
  parameter logic [AW-1:0] HL_INIT = 16'h4250,
  parameter logic [DW-1:0] A_INIT  = 8'hC7,
  parameter logic [DW-1:0] B_INIT  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rd_data,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic [2:0]       mc_type,
  output logic [2:0]       tstate,
  output logic [DW-1:0]    acc_out,
  output logic [DW-1:0]    b_out
);
  localparam int TW = 3;
  localparam int SW = 2;

  logic          rst_q;
  mc_e           mc_q, mc_d;
  asel_e         asel_q, asel_d;
  logic [SW-1:0] step_q, step_d, dec_step;
  logic [DW-1:0] opc_q, opc_d, a_q, a_d, b_q, b_d;
  logic [AW-1:0] pc_q, pc_d, hl_q, wz_q, wz_d, bus_addr;
  logic [DW-1:0] wdata;
  logic [TW-1:0] t_q;
  logic          t_last, cap_en, dec_valid, is_rd, is_wr, strobe_win;
  mc_e           dec_mc;
  asel_e         dec_asel;

  bseq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  bseq_tstate #(.TW(TW)) u_tst (
    .clk(clk), .rst_n(rst_q), .four(mc_q == MC_OF), .t_q(t_q), .last(t_last)
  );

  assign dec_step = (mc_q == MC_OF) ? SW'(1) : step_q + SW'(1);

  bseq_decode #(.DW(DW), .SW(SW)) u_dec (
    .opc(opc_q), .step(dec_step), .valid(dec_valid), .mc(dec_mc), .asel(dec_asel)
  );

  // capture enable: rising edge that closes T3
  assign cap_en = (t_q == TW'(3));

  // next-state process
  always_comb begin
    mc_d   = mc_q;
    asel_d = asel_q;
    step_d = step_q;
    opc_d  = opc_q;
    pc_d   = pc_q;
    wz_d   = wz_q;
    a_d    = a_q;
    b_d    = b_q;
    if (cap_en) begin
      case (mc_q)
        MC_OF: begin
          opc_d = rd_data;
          pc_d  = pc_q + AW'(1);
        end
        MC_MR: begin
          wz_d = {rd_data, wz_q[AW-1:DW]};
          if (asel_q == AS_PC) pc_d = pc_q + AW'(1);
          if (opc_q == OP_LD_B) b_d = rd_data;
        end
        MC_IOR: a_d = rd_data;
        default: ;
      endcase
    end
    if (t_last) begin
      if (dec_valid) begin
        mc_d   = dec_mc;
        asel_d = dec_asel;
        step_d = dec_step;
      end else begin
        mc_d   = MC_OF;
        asel_d = AS_PC;
        step_d = '0;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mc_q   <= MC_OF;
      asel_q <= AS_PC;
      step_q <= '0;
      opc_q  <= '0;
      pc_q   <= PC_INIT;
      hl_q   <= HL_INIT;
      wz_q   <= '0;
      a_q    <= A_INIT;
      b_q    <= B_INIT;
    end else begin
      mc_q   <= mc_d;
      asel_q <= asel_d;
      step_q <= step_d;
      opc_q  <= opc_d;
      pc_q   <= pc_d;
      hl_q   <= hl_q;
      wz_q   <= wz_d;
      a_q    <= a_d;
      b_q    <= b_d;
    end
  end

  // address and write-data selection
  always_comb begin
    case (asel_q)
      AS_HL:   bus_addr = hl_q;
      AS_WZ:   bus_addr = wz_q;
      AS_PORT: bus_addr = {wz_q[AW-1 -: DW], wz_q[AW-1 -: DW]};
      default: bus_addr = pc_q;
    endcase
    wdata = (opc_q == OP_INC_IND) ? wz_q[AW-1 -: DW] + DW'(1) : a_q;
  end

  assign is_rd      = (mc_q == MC_OF) || (mc_q == MC_MR) || (mc_q == MC_IOR);
  assign is_wr      = (mc_q == MC_MW) || (mc_q == MC_IOW);
  assign strobe_win = (t_q == TW'(2)) || (t_q == TW'(3));

  assign ale     = (t_q == TW'(1));
  assign rd_n    = ~(strobe_win && is_rd);
  assign wr_n    = ~(strobe_win && is_wr);
  assign io_m    = (mc_q == MC_IOR) || (mc_q == MC_IOW);
  assign addr_hi = bus_addr[AW-1:DW];
  assign ad_out  = ale ? bus_addr[DW-1:0] : ((strobe_win && is_wr) ? wdata : '0);
  assign mc_type = mc_q;
  assign tstate  = t_q;
  assign acc_out = a_q;
  assign b_out   = b_q;
endmodule

// File: rtl/bus_sequencer_chk.sv
`timescale 1ns/1ps
module bus_sequencer_chk (
  input logic       clk,
  input logic       rst_q,
  input logic [2:0] mc_type,
  input logic [2:0] tstate,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       io_m,
  input logic [7:0] ad_out
);
  // fetch T4 is internal: no strobe
  assert_fetch_t4_quiet_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (mc_type == 3'd0 && tstate == 3'd4) |-> (rd_n && wr_n));

  // non-fetch cycles end after T3
  assert_three_state_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (mc_type != 3'd0 && tstate == 3'd3) |=> (tstate == 3'd1));

  assert_fetch_len_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (mc_type == 3'd0 && tstate == 3'd3) |=> (tstate == 3'd4 && mc_type == 3'd0));

  assert_ale_t1_only_R4: assert property (@(posedge clk) disable iff (!rst_q)
    ale |-> (tstate == 3'd1 && rd_n && wr_n));

  assert_strobes_excl_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !(!rd_n && !wr_n));

  assert_wdata_held_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (!wr_n && tstate == 3'd2) |=> (!wr_n && $stable(ad_out)));

  assert_io_select_R8: assert property (@(posedge clk) disable iff (!rst_q)
    io_m |-> (mc_type == 3'd3 || mc_type == 3'd4));

  assert_tstate_advance_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (tstate == 3'd1) |=> (tstate == 3'd2 && $stable(mc_type)));
endmodule

bind bus_sequencer bus_sequencer_chk i_chk (
  .clk(clk), .rst_q(rst_q), .mc_type(mc_type), .tstate(tstate), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .ad_out(ad_out)
);

// File: tb/test_bus_sequencer.sv
`timescale 1ns/1ps
module test_bus_sequencer;
  logic       clk;
  logic       rst_n;
  logic [7:0] rd_data, addr_hi, ad_out, acc_out, b_out;
  logic       ale, rd_n, wr_n, io_m;
  logic [2:0] mc_type, tstate;
  logic [15:0] lat_addr;
  logic        lat_io;
  int checks, errors, cyc;

  bus_sequencer i_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .addr_hi(addr_hi), .ad_out(ad_out),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .mc_type(mc_type),
    .tstate(tstate), .acc_out(acc_out), .b_out(b_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] lookup(input logic [15:0] a, input logic io);
    if (io) return (a == 16'hC0C0) ? 8'h5E : 8'h00;
    case (a)
      16'h2000: return 8'h34;  16'h4250: return 8'h12;
      16'h2001: return 8'h06;  16'h2002: return 8'h43;
      16'h2003: return 8'h32;  16'h2004: return 8'h6A;  16'h2005: return 8'h52;
      16'h2006: return 8'hDB;  16'h2007: return 8'hC0;
      16'h2008: return 8'h32;  16'h2009: return 8'h6B;  16'h200A: return 8'h52;
      16'h200B: return 8'hFF;
      default:  return 8'h00;
    endcase
  endfunction

  always @(negedge clk) if (ale) begin
    lat_addr <= {addr_hi, ad_out};
    lat_io   <= io_m;
  end
  assign rd_data = lookup(lat_addr, lat_io);

  initial begin
    lat_addr = 16'h0;
    lat_io   = 1'b0;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Walks one machine cycle; called at the falling edge inside its T1, returns at the next T1.
  task automatic expect_cycle(input string req, input logic [2:0] mc, input int len,
                              input logic [15:0] addr, input logic io, input logic [7:0] wd);
    logic [23:0] a1, e1;
    logic [17:0] ak, ek;
    bit bad;
    logic [31:0] bad_a, bad_e;
    bool_rd_wr: begin end
    bad = 1'b0; bad_a = '0; bad_e = '0;
    a1 = {mc_type, tstate, ale, io_m, addr_hi, ad_out};
    e1 = {mc, 3'd1, 1'b1, io, addr};
    if (a1 !== e1) begin bad = 1'b1; bad_a = 32'(a1); bad_e = 32'(e1); end
    for (int k = 2; k <= len; k++) begin
      @(negedge clk);
      ak = {mc_type, tstate, ale, rd_n, wr_n, io_m, ad_out};
      if (k <= 3)
        ek = {mc, 3'(k), 1'b0, !(mc == 3'd0 || mc == 3'd1 || mc == 3'd3),
              !(mc == 3'd2 || mc == 3'd4), io, (mc == 3'd2 || mc == 3'd4) ? wd : 8'h00};
      else
        ek = {mc, 3'(k), 1'b0, 1'b1, 1'b1, io, 8'h00};
      if (!bad && ak !== ek) begin bad = 1'b1; bad_a = 32'(ak); bad_e = 32'(ek); end
    end
    @(negedge clk);
    check(req, $sformatf("cycle type %0d at %h", mc, addr), bad ? bad_a : 32'h0, bad ? bad_e : 32'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle fetch state at reset value of the program counter
    check("R1", "reset state", {mc_type, tstate, rd_n, wr_n, io_m, addr_hi, ad_out},
          {3'd0, 3'd1, 1'b1, 1'b1, 1'b0, 16'h2000});
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_inc_ind;  // R5, R2, R3, R4
    expect_cycle("R5/R2", 3'd0, 4, 16'h2000, 1'b0, 8'h00);
    expect_cycle("R5/R3", 3'd1, 3, 16'h4250, 1'b0, 8'h00);
    expect_cycle("R5/R4", 3'd2, 3, 16'h4250, 1'b0, 8'h13);
  endtask

  task automatic t_ld_b;  // R6, R9
    expect_cycle("R6", 3'd0, 4, 16'h2001, 1'b0, 8'h00);
    expect_cycle("R6/R9", 3'd1, 3, 16'h2002, 1'b0, 8'h00);
    check("R6", "b_out", 32'(b_out), 32'h43);
  endtask

  task automatic t_st_dir;  // R7, R4
    check("R7", "acc before store", 32'(acc_out), 32'hC7);
    expect_cycle("R7", 3'd0, 4, 16'h2003, 1'b0, 8'h00);
    expect_cycle("R7", 3'd1, 3, 16'h2004, 1'b0, 8'h00);
    expect_cycle("R7", 3'd1, 3, 16'h2005, 1'b0, 8'h00);
    expect_cycle("R7/R4", 3'd2, 3, 16'h526A, 1'b0, 8'hC7);
  endtask

  task automatic t_port_in;  // R8, R11
    expect_cycle("R8", 3'd0, 4, 16'h2006, 1'b0, 8'h00);
    expect_cycle("R8", 3'd1, 3, 16'h2007, 1'b0, 8'h00);
    expect_cycle("R8/R11", 3'd3, 3, 16'hC0C0, 1'b1, 8'h00);
    check("R8", "acc_out", 32'(acc_out), 32'h5E);
  endtask

  task automatic t_pc_skip;  // R9: data cycles did not move the program counter
    expect_cycle("R9", 3'd0, 4, 16'h2008, 1'b0, 8'h00);
    expect_cycle("R9", 3'd1, 3, 16'h2009, 1'b0, 8'h00);
    expect_cycle("R9", 3'd1, 3, 16'h200A, 1'b0, 8'h00);
    expect_cycle("R9/R7", 3'd2, 3, 16'h526B, 1'b0, 8'h5E);
  endtask

  task automatic t_unknown;  // R10
    expect_cycle("R10", 3'd0, 4, 16'h200B, 1'b0, 8'h00);
    expect_cycle("R10", 3'd0, 4, 16'h200C, 1'b0, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_inc_ind();
    t_ld_b();
    t_st_dir();
    t_port_in();
    t_pc_skip();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule